// File: doc/BRIEF.md
# Mapped-Vertex Subgraph Search Engine

This block decides whether a small pattern graph can be embedded in a target graph. The embedding must be one-to-one on vertices and must keep every pattern edge. Both graphs have at most 15 vertices. Each graph is held as an adjacency matrix, one row per vertex, and the rows are written through a simple row-write port. The caller then sets the two vertex counts and pulses `start`.

The engine searches depth first. At each level it gives the next pattern vertex the lowest-numbered target vertex that is still free. A candidate is kept only if the target matrix holds an edge for every pattern edge that links the new vertex to a vertex mapped earlier. Only vertices that are already mapped are examined, and the engine keeps no matrix of candidates. On a dead end it steps back one level and moves that level on to its next candidate. The engine reports found or not-found, the first mapping it reached, and the number of cycles the search took.

Top module: `sgi_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine goes idle. After that edge `busy`, `done`, `found`, `map_flat` and `cycle_count` all read 0.
- R2: When `wr_en` is high and the engine is not busy, `wr_data` is stored as row `wr_row`. It goes to the pattern matrix when `wr_tgt` is 0 and to the target matrix when `wr_tgt` is 1. Bit j of row i means an edge between vertex i and vertex j. A write made while `busy` is high changes nothing.
- R3: `start` is taken only while the engine is idle, and a `start` pulse while busy has no effect. For a non-empty pattern, `busy` is high from the cycle after `start` until the cycle in which `done` rises.
- R4: `found` is 1 exactly when an injective map from pattern vertices 0..n_pat-1 to target vertices 0..n_tgt-1 exists such that every edge (k,i) with k<i in the pattern maps to an edge in the target.
- R5: The reported mapping is the first one met when candidates are tried in increasing index order, depth first. Field i of `map_flat` is bits [4i+3:4i] and holds the target vertex for pattern vertex i. Fields at or above n_pat read 0, and every field reads 0 when nothing was found.
- R6: No target vertex appears twice in a reported mapping.
- R7: When n_pat is 0, the result is found, with 0 busy cycles. When n_pat is greater than n_tgt, the result is not found.
- R8: `done` is high for exactly one cycle. `found` and `map_flat` then hold their values until the next accepted `start`.
- R9: `cycle_count` is cleared when `start` is taken and goes up by one in each busy cycle. When done, it equals the number of cycles in which `busy` was high. A one-vertex pattern for which target vertex 0 is free costs 1 cycle.
- R10: Each step costs one cycle: a free-candidate test, a skip over a used vertex, or a backtrack. The edge test of a candidate at level i looks at one earlier vertex per cycle, takes at most i cycles, and stops at the first missing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_tgt | input | 1 | 0 selects the pattern matrix, 1 the target matrix |
| wr_row | input | 4 | Row index of the write |
| wr_data | input | 15 | Adjacency row, bit j means an edge to vertex j |
| n_pat | input | 4 | Pattern vertex count |
| n_tgt | input | 4 | Target vertex count |
| start | input | 1 | Start pulse, taken only when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Embedding exists |
| map_flat | output | 60 | Mapping, 4 bits per pattern vertex |
| cycle_count | output | 32 | Busy cycles of the last search |

## Verification
The hardest paths to reach from the ports are backtracks that cross several levels, the candidate cursor restarting one past the vertex it just released, and the search running out at level zero. A three-vertex pattern is swept over all 8 of its edge sets against all 64 edge sets of a four-vertex target. That sweep drives every such path, and every result is compared with an independent search done in the bench. Writes and a second `start` are also injected in the middle of a long search on 15 vertices. This shows that neither one disturbs the result or the cycle count.

// File: rtl/sgi_pkg.sv
// Shared types of the subgraph search engine.
package sgi_pkg;
    // Search controller states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PICK   = 2'd1,
        ST_CHECK  = 2'd2,
        ST_FINISH = 2'd3
    } sgi_state_t;
endpackage

// File: rtl/sgi_adj_store.sv
// Holds the pattern and target adjacency matrices as register rows.
// Assumes: the caller gates wr_en while a search runs. Rows are padded
// to DEPTH bits, so every index of IDX_W bits is in range.
module sgi_adj_store #(
    parameter int MAX_V = 15,
    parameter int IDX_W = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_tgt,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [MAX_V-1:0] wr_data,
    input  logic [IDX_W-1:0] pat_sel,
    output logic [DEPTH-1:0] pat_row,
    input  logic [IDX_W-1:0] tgt_r,
    input  logic [IDX_W-1:0] tgt_c,
    output logic             tgt_bit
);
    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(MAX_V - 1);

    logic [DEPTH-1:0] pat_m [DEPTH];
    logic [DEPTH-1:0] tgt_m [DEPTH];
    logic [DEPTH-1:0] tgt_row;

    // Row write into the selected matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pat_m[i] <= '0;
                tgt_m[i] <= '0;
            end
        end else if (wr_en && (wr_row <= LAST_ROW)) begin
            if (wr_tgt) tgt_m[wr_row] <= DEPTH'(wr_data);
            else        pat_m[wr_row] <= DEPTH'(wr_data);
        end
    end

    // Read ports: one pattern row and one target bit.
    always_comb begin
        pat_row = pat_m[pat_sel];
        tgt_row = tgt_m[tgt_r];
        tgt_bit = tgt_row[tgt_c];
    end
endmodule

// File: rtl/sgi_cycle_counter.sv
// Counts the busy cycles of one search.
// Assumes: clr and en are never high together.
module sgi_cycle_counter #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CYC_W-1:0] count
);
    // Clear on an accepted start, step while searching.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (en)  count <= count + CYC_W'(1);
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (count == $past(count) + CYC_W'(1)));
    assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/sgi_search_ctrl.sv
// Depth-first search controller. It gives pattern vertex lvl the lowest
// free target vertex whose edges back to the vertices mapped earlier all
// exist, and backtracks when a level runs out of candidates.
// Assumes: n_pat and n_tgt are held stable while busy.
module sgi_search_ctrl
    import sgi_pkg::*;
#(
    parameter int MAX_V = 15,
    parameter int IDX_W = 4,
    parameter int CNT_W = 4,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CNT_W-1:0]       n_pat,
    input  logic [CNT_W-1:0]       n_tgt,
    input  logic [DEPTH-1:0]       pat_row,
    input  logic                   tgt_bit,
    output logic [IDX_W-1:0]       pat_sel,
    output logic [IDX_W-1:0]       tgt_r,
    output logic [IDX_W-1:0]       tgt_c,
    output logic                   busy,
    output logic                   done,
    output logic                   found,
    output logic [MAX_V*IDX_W-1:0] map_flat,
    output logic                   count_clr,
    output logic                   count_en
);
    sgi_state_t       state;
    logic [IDX_W-1:0] lvl;
    logic [CNT_W-1:0] cand;
    logic [IDX_W-1:0] kk;
    logic [DEPTH-1:0] used;
    logic [IDX_W-1:0] map_q [DEPTH];
    logic             found_q;

    logic [IDX_W-1:0] cand_idx, prev_idx, prev_map;
    logic cand_out, cand_used, pat_bit, edge_bad, last_k, at_last, accept;

    // Decode of the current step.
    always_comb begin
        cand_idx  = IDX_W'(cand);
        prev_idx  = lvl - IDX_W'(1);
        prev_map  = map_q[prev_idx];
        cand_out  = (cand >= n_tgt);
        cand_used = used[cand_idx];
        pat_bit   = pat_row[kk];
        edge_bad  = pat_bit && !tgt_bit;
        last_k    = ((kk + IDX_W'(1)) == lvl);
        at_last   = ((CNT_W'(lvl) + CNT_W'(1)) == n_pat);
        accept    = ((state == ST_PICK) && !cand_out && !cand_used && (lvl == '0))
                 || ((state == ST_CHECK) && !edge_bad && last_k);
        pat_sel   = lvl;
        tgt_r     = map_q[kk];
        tgt_c     = cand_idx;
        busy      = (state == ST_PICK) || (state == ST_CHECK);
        done      = (state == ST_FINISH);
        found     = found_q;
        count_clr = (state == ST_IDLE) && start;
        count_en  = busy;
    end

    // Search state: level, candidate cursor, edge cursor, used set, mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lvl     <= '0;
            cand    <= '0;
            kk      <= '0;
            used    <= '0;
            found_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) map_q[i] <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        used <= '0;
                        lvl  <= '0;
                        cand <= '0;
                        kk   <= '0;
                        for (int i = 0; i < DEPTH; i++) map_q[i] <= '0;
                        if (n_pat == '0) begin
                            found_q <= 1'b1;
                            state   <= ST_FINISH;
                        end else begin
                            found_q <= 1'b0;
                            state   <= ST_PICK;
                        end
                    end
                end
                ST_PICK: begin
                    if (cand_out) begin
                        if (lvl == '0) begin
                            state <= ST_FINISH;
                        end else begin
                            lvl            <= prev_idx;
                            used[prev_map] <= 1'b0;
                            cand           <= CNT_W'(prev_map) + CNT_W'(1);
                        end
                    end else if (cand_used) begin
                        cand <= cand + CNT_W'(1);
                    end else if (lvl != '0) begin
                        kk    <= '0;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (edge_bad) begin
                        cand  <= cand + CNT_W'(1);
                        state <= ST_PICK;
                    end else if (!last_k) begin
                        kk <= kk + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (accept) begin
                map_q[lvl]     <= cand_idx;
                used[cand_idx] <= 1'b1;
                if (at_last) begin
                    found_q <= 1'b1;
                    state   <= ST_FINISH;
                end else begin
                    lvl   <= lvl + IDX_W'(1);
                    cand  <= '0;
                    state <= ST_PICK;
                end
            end
        end
    end

    // Mapping fields, zero unless a match was found.
    for (genvar g = 0; g < MAX_V; g++) begin : g_map
        assign map_flat[g*IDX_W +: IDX_W] = found_q ? map_q[g] : '0;
    end

    assert_used_tracks_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(used) == int'(lvl)));
    assert_check_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK) |-> (kk < lvl));
    assert_found_full_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found_q) |-> ($countones(used) == int'(n_pat)));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_found_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !start) |=> $stable(found_q));
    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && start && (n_pat != '0)) |=> busy);
endmodule

// File: rtl/sgi_engine.sv
// Top of the subgraph search engine: matrix store, search controller and
// cycle counter. Assumes: the vertex counts are held during a search.
module sgi_engine #(
    parameter  int MAX_V = 15,
    parameter  int CYC_W = 32,
    localparam int IDX_W = $clog2(MAX_V),
    localparam int CNT_W = $clog2(MAX_V + 1),
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_tgt,
    input  logic [IDX_W-1:0]       wr_row,
    input  logic [MAX_V-1:0]       wr_data,
    input  logic [CNT_W-1:0]       n_pat,
    input  logic [CNT_W-1:0]       n_tgt,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   found,
    output logic [MAX_V*IDX_W-1:0] map_flat,
    output logic [CYC_W-1:0]       cycle_count
);
    logic [DEPTH-1:0] pat_row;
    logic [IDX_W-1:0] pat_sel, tgt_r, tgt_c;
    logic             tgt_bit, count_clr, count_en, wr_ok;

    // Writes are only let through while no search runs.
    assign wr_ok = wr_en && !busy;

    sgi_adj_store #(.MAX_V(MAX_V), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_tgt(wr_tgt),
        .wr_row(wr_row), .wr_data(wr_data), .pat_sel(pat_sel),
        .pat_row(pat_row), .tgt_r(tgt_r), .tgt_c(tgt_c), .tgt_bit(tgt_bit)
    );

    sgi_search_ctrl #(.MAX_V(MAX_V), .IDX_W(IDX_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .n_pat(n_pat), .n_tgt(n_tgt),
        .pat_row(pat_row), .tgt_bit(tgt_bit), .pat_sel(pat_sel), .tgt_r(tgt_r),
        .tgt_c(tgt_c), .busy(busy), .done(done), .found(found),
        .map_flat(map_flat), .count_clr(count_clr), .count_en(count_en)
    );

    sgi_cycle_counter #(.CYC_W(CYC_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(count_clr), .en(count_en),
        .count(cycle_count)
    );
endmodule

// File: tb/sgi_engine_bench.sv
`timescale 1ns/1ps
module sgi_engine_bench;
    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_tgt = 1'b0, start = 1'b0;
    logic [3:0]  wr_row = '0, n_pat = '0, n_tgt = '0;
    logic [14:0] wr_data = '0;
    wire         busy, done, found;
    wire  [59:0] map_flat;
    wire  [31:0] cycle_count;

    sgi_engine u_sgi_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_row(wr_row),
        .wr_data(wr_data), .n_pat(n_pat), .n_tgt(n_tgt), .start(start),
        .busy(busy), .done(done), .found(found), .map_flat(map_flat),
        .cycle_count(cycle_count)
    );

    always #2 clk = ~clk;

    bit pa [15][15];
    bit tm [15][15];
    int np_i, nt_i, checks = 0, errors = 0, busy_cyc;
    bit r_found, got_found, fin = 1'b0;
    int r_map [15];
    logic [59:0] got_map;
    logic [31:0] got_cnt;
    int seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_graphs();
        for (int i = 0; i < 15; i++)
            for (int j = 0; j < 15; j++) begin
                pa[i][j] = 1'b0;
                tm[i][j] = 1'b0;
            end
    endtask

    task automatic pe(input int a, input int b); pa[a][b] = 1'b1; pa[b][a] = 1'b1; endtask
    task automatic te(input int a, input int b); tm[a][b] = 1'b1; tm[b][a] = 1'b1; endtask

    // Writes all 15 rows of both matrices, one row per cycle.
    task automatic load();
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 15; r++) begin
                wr_en  = 1'b1;
                wr_tgt = (m == 1);
                wr_row = 4'(r);
                for (int j = 0; j < 15; j++) wr_data[j] = (m == 1) ? tm[r][j] : pa[r][j];
                @(negedge clk);
            end
        wr_en = 1'b0;
        n_pat = 4'(np_i);
        n_tgt = 4'(nt_i);
    endtask

    // Independent depth-first search in increasing candidate order.
    task automatic ref_search();
        int lvl, c;
        bit ok;
        bit ru [15];
        for (int i = 0; i < 15; i++) begin ru[i] = 1'b0; r_map[i] = 0; end
        r_found = 1'b0;
        if (np_i == 0) begin r_found = 1'b1; return; end
        lvl = 0; c = 0;
        while (1) begin
            if (c >= nt_i) begin
                if (lvl == 0) break;
                lvl--;
                ru[r_map[lvl]] = 1'b0;
                c = r_map[lvl] + 1;
                continue;
            end
            if (ru[c]) begin c++; continue; end
            ok = 1'b1;
            for (int k = 0; k < lvl; k++) if (pa[lvl][k] && !tm[r_map[k]][c]) ok = 1'b0;
            if (!ok) begin c++; continue; end
            r_map[lvl] = c;
            ru[c] = 1'b1;
            if (lvl == np_i - 1) begin r_found = 1'b1; break; end
            lvl++;
            c = 0;
        end
        if (!r_found) for (int i = 0; i < 15; i++) r_map[i] = 0;
    endtask

    // Starts a search and counts busy cycles until done. With poke, a row
    // write and a second start are driven in the middle of the search.
    task automatic run(input bit poke);
        int wd;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        busy_cyc = 0; wd = 0;
        while (!done && wd < 30000) begin
            if (busy) busy_cyc++;
            if (poke && wd == 1) begin
                wr_en = 1'b1; wr_tgt = 1'b1; wr_row = 4'd3; wr_data = '0; start = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
            wd++;
        end
        chk(wd < 30000, "R3", "watchdog on done", wd, 30000);
        got_found = found; got_map = map_flat; got_cnt = cycle_count;
    endtask

    task automatic verify();
        logic [59:0] exp_map;
        bit inj, edges;
        ref_search();
        exp_map = '0;
        for (int i = 0; i < 15; i++) if (r_found && i < np_i) exp_map[i*4 +: 4] = 4'(r_map[i]);
        chk(got_found == r_found, "R4", "found", got_found, r_found);
        chk(got_map == exp_map, "R5", "mapping", got_map, exp_map);
        chk(got_cnt == 32'(busy_cyc), "R9", "cycle count", got_cnt, busy_cyc);
        if (got_found) begin
            inj = 1'b1; edges = 1'b1;
            for (int i = 0; i < np_i; i++)
                for (int k = 0; k < i; k++) begin
                    if (got_map[i*4 +: 4] == got_map[k*4 +: 4]) inj = 1'b0;
                    if (pa[i][k] && !tm[got_map[k*4 +: 4]][got_map[i*4 +: 4]]) edges = 1'b0;
                end
            chk(inj, "R6", "one-to-one", inj, 1);
            chk(edges, "R4", "edges kept", edges, 1);
        end
        @(negedge clk);
        chk(!done && found == got_found && map_flat == got_map, "R8",
            "hold after done", {done, found}, {1'b0, got_found});
    endtask

    function automatic int rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !found && map_flat == '0 && cycle_count == '0, "R1",
            "reset outputs", {busy, done, found}, 0);
        rst_n = 1'b1;

        // R7: empty pattern, then a pattern larger than the target
        clear_graphs(); np_i = 0; nt_i = 4; load(); run(0); verify();
        chk(got_found && got_cnt == 0, "R7", "empty pattern", got_cnt, 0);
        clear_graphs(); np_i = 5; nt_i = 3; load(); run(0); verify();
        chk(!got_found, "R7", "pattern too large", got_found, 0);

        // R9: one vertex costs one cycle
        clear_graphs(); np_i = 1; nt_i = 3; load(); run(0); verify();
        chk(got_cnt == 1, "R9", "single vertex count", got_cnt, 1);

        // R10: exact step costs
        clear_graphs(); np_i = 2; nt_i = 2; pe(0, 1); te(0, 1); load(); run(0); verify();
        chk(got_cnt == 4, "R10", "two vertex direct", got_cnt, 4);
        clear_graphs(); np_i = 2; nt_i = 3; pe(0, 1); te(0, 2); load(); run(0); verify();
        chk(got_cnt == 6 && got_map[7:4] == 4'd2, "R10", "one failed candidate", got_cnt, 6);

        // R2, R3: 15-vertex path with a write and a start injected while busy
        clear_graphs(); np_i = 15; nt_i = 15;
        for (int i = 0; i < 14; i++) begin pe(i, i + 1); te(i, i + 1); end
        load(); run(1); verify();
        chk(got_found && got_map[59:56] == 4'd14, "R3", "start/write while busy ignored",
            got_map[59:56], 14);
        run(0); verify();
        chk(got_found, "R2", "target row kept after busy write", got_found, 1);

        // Exhaustive sweep: 3-vertex patterns against 4-vertex targets
        for (int p = 0; p < 8; p++)
            for (int t = 0; t < 64; t++) begin
                clear_graphs(); np_i = 3; nt_i = 4;
                if (p[0]) pe(0, 1);
                if (p[1]) pe(0, 2);
                if (p[2]) pe(1, 2);
                if (t[0]) te(0, 1);
                if (t[1]) te(0, 2);
                if (t[2]) te(0, 3);
                if (t[3]) te(1, 2);
                if (t[4]) te(1, 3);
                if (t[5]) te(2, 3);
                load(); run(0); verify();
            end

        // Pseudo-random 4-in-6 cases
        for (int n = 0; n < 20; n++) begin
            clear_graphs(); np_i = 4; nt_i = 6;
            for (int i = 0; i < 4; i++) for (int j = 0; j < i; j++) if (rnd() % 3 == 0) pe(i, j);
            for (int i = 0; i < 6; i++) for (int j = 0; j < i; j++) if (rnd() % 2 == 0) te(i, j);
            load(); run(0); verify();
        end

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!fin) begin
            checks++; errors++;
            $display("FAIL R3 global watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule